// File: doc/BRIEF.md
# Watchdog Timer with Stop-Mode Wake Sequencing

This block is a 12-bit down-counting watchdog for a small microcontroller. In normal running it counts ticks from one of two prescaled clock enables, a divide-by-32 tick or a divide-by-512 tick. It raises a one-cycle interrupt request each time the counter's top bit falls from 1 to 0. Software keeps the request away by strobing a refresh input, which reloads the counter with all ones. The counter freezes during wait mode and picks up again from the value it held.

The same counter also times oscillator settling when the chip leaves stop mode. The stop instruction loads all ones and halts the counter. An interrupt then ends stop mode, and what happens next depends on the stop-use enable input:
- If the enable is set, the CPU/bus clock enable stays low while the counter runs from a separate stabilization source. The enable is released when the top bit clears, and no interrupt request is raised for that event.
- If the enable is clear, the clocks return at once.

In both cases the counter then restarts from all ones on the tick source that was in use before the stop instruction.

The controller is a four-state machine:
- RUN: normal counting.
- WAIT: frozen for wait mode.
- STOP: halted in stop mode.
- STAB: stabilization count after an interrupt wake.

It has these transitions:
- RUN→STOP on the stop instruction.
- RUN→WAIT on wait mode.
- WAIT→RUN when wait mode ends.
- STOP→STAB on a wake interrupt with stop-use set.
- STOP→RUN on a wake interrupt with stop-use clear.
- STAB→RUN when the top bit clears.
- Any state→RUN on hardware reset.

Top module: `wdt_wake_ctrl`

## Requirements
- R1: After hardware reset, including a reset taken during stop mode, the clock enable is 1, the interrupt request is 0, the rate bit is 0 and the counter counts divide-by-512 ticks from 0xFFF.
- R2: In RUN the counter drops by one per selected tick. A control write (`ctl_we`) is accepted in RUN and takes data bit 0 as the rate bit and bits 7:6 as the wake-source field. Rate bit 0 selects the divide-by-512 tick and rate bit 1 selects the divide-by-32 tick.
- R3: In RUN, when a tick takes the counter from 0x800 to 0x7FF, `wdt_irq` is high for exactly the one following cycle.
- R4: A refresh strobe in RUN reloads 0xFFF, so refreshing more often than the timeout period raises no request.
- R5: While wait mode is held the counter is frozen. When wait mode drops, counting resumes from the held value without a reload.
- R6: The stop instruction in RUN loads 0xFFF and enters STOP. In STOP the counter holds and the clock enable is 0 from the cycle after the instruction.
- R7: A wake interrupt with stop-use set enters STAB. In STAB the counter runs from 0xFFF on the tick chosen by the wake-source field (00 = divide-by-32, 01 = divide-by-512, 10 or 11 = divide-by-128), and the rate bit is ignored. The clock enable stays 0 until the top bit clears, then goes to 1 with no interrupt request.
- R8: On leaving STAB the counter reloads 0xFFF and counts the tick that was selected in RUN before the stop instruction.
- R9: A wake interrupt with stop-use clear returns to RUN with the clock enable 1 in the next cycle, the counter at 0xFFF and the pre-stop tick selected.
- R10: In RUN, when several requests arrive in the same cycle, the stop instruction wins over wait mode, wait mode wins over refresh, and refresh wins over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| tick_d32 | input | 1 | Divide-by-32 tick enable |
| tick_d128 | input | 1 | Divide-by-128 stabilization tick enable |
| tick_d512 | input | 1 | Divide-by-512 tick enable |
| wait_mode | input | 1 | High while the chip is in wait mode |
| stop_exec | input | 1 | One-cycle pulse when the stop instruction executes |
| wake_irq | input | 1 | One-cycle pulse: interrupt ending stop mode |
| stop_use | input | 1 | Watchdog used as the stabilization timer after stop |
| refresh | input | 1 | Software refresh strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control write data (bit 0 rate, bits 7:6 wake source) |
| wdt_irq | output | 1 | Watchdog interrupt request pulse |
| cpu_clk_en | output | 1 | CPU/bus clock enable |

## Verification
`cpu_clk_en` is a decode of the state register:
- It changes in the cycle right after the rising edge that samples a stop instruction, a wake interrupt or the final stabilization tick.
- `wdt_irq` comes from a register, so it is high during the cycle after the edge at which the counter passes from 0x800 to 0x7FF.

The bench drives inputs and samples outputs on the falling edge. Its reference model steps on the rising edge, so every comparison falls half a cycle after the edge that produced the value. Directed checks are placed to suit this timing. The wake-latency checks are one falling edge after the wake pulse. The settling-time checks count falling edges until the enable rises and compare that count with the tick period of the chosen source.

// File: rtl/wdt_wake_pkg.sv
package wdt_wake_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2,
        ST_STAB = 2'd3
    } wdt_state_e;

    // wake-source field encodings
    localparam logic [1:0] WSRC_D32  = 2'b00;
    localparam logic [1:0] WSRC_D512 = 2'b01;

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel (
    input  logic       tick_d32,
    input  logic       tick_d128,
    input  logic       tick_d512,
    input  logic       stab_mode,
    input  logic       run_fast,
    input  logic [1:0] wake_src,
    output logic       tick
);
    import wdt_wake_pkg::*;

    logic stab_tick;
    logic run_tick;

    always_comb begin
        unique case (wake_src)
            WSRC_D32:  stab_tick = tick_d32;
            WSRC_D512: stab_tick = tick_d512;
            default:   stab_tick = tick_d128;
        endcase
    end

    assign run_tick = run_fast ? tick_d32 : tick_d512;
    assign tick     = stab_mode ? stab_tick : run_tick;

endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_edge
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EDGE_VAL = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ALL_ONES;
        end else if (load) begin
            cnt_q <= ALL_ONES;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt     = cnt_q;
    // next decrement clears the top bit
    assign at_edge = (cnt_q == EDGE_VAL);

endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg #(
    parameter int CTL_W    = 8,
    parameter int RATE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             capture,
    input  logic             restore,
    output logic             run_fast,
    output logic [1:0]       wake_src
);
    localparam int SRC_MSB = CTL_W - 1;

    logic       fast_q;
    logic       saved_q;
    logic [1:0] src_q;
    logic       unused_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q  <= 1'b0;
            saved_q <= 1'b0;
            src_q   <= 2'b00;
        end else begin
            if (capture) begin
                saved_q <= fast_q;
            end
            if (restore) begin
                fast_q <= saved_q;
            end else if (wr_en) begin
                fast_q <= wdata[RATE_BIT];
            end
            if (wr_en) begin
                src_q <= wdata[SRC_MSB -: 2];
            end
        end
    end

    assign unused_wdata = ^wdata;
    assign run_fast     = fast_q;
    assign wake_src     = src_q;

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stop_exec,
    input  logic                      wait_mode,
    input  logic                      wake_irq,
    input  logic                      stop_use,
    input  logic                      refresh,
    input  logic                      tick,
    input  logic                      at_edge,
    output wdt_wake_pkg::wdt_state_e  state,
    output logic                      cnt_load,
    output logic                      cnt_dec,
    output logic                      src_capture,
    output logic                      src_restore,
    output logic                      wr_ok,
    output logic                      stab_mode,
    output logic                      irq,
    output logic                      clk_en
);
    import wdt_wake_pkg::*;

    wdt_state_e state_q;
    wdt_state_e state_d;
    logic       irq_set;
    logic       irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_set;
        end
    end

    // next state and counter control
    always_comb begin
        state_d     = state_q;
        cnt_load    = 1'b0;
        cnt_dec     = 1'b0;
        src_capture = 1'b0;
        src_restore = 1'b0;
        irq_set     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_exec) begin
                    state_d     = ST_STOP;
                    cnt_load    = 1'b1;
                    src_capture = 1'b1;
                end else if (wait_mode) begin
                    state_d = ST_WAIT;
                end else if (refresh) begin
                    cnt_load = 1'b1;
                end else if (tick) begin
                    cnt_dec = 1'b1;
                    irq_set = at_edge;
                end
            end
            ST_WAIT: begin
                if (!wait_mode) begin
                    state_d = ST_RUN;
                end
            end
            ST_STOP: begin
                if (wake_irq) begin
                    cnt_load = 1'b1;
                    if (stop_use) begin
                        state_d = ST_STAB;
                    end else begin
                        state_d     = ST_RUN;
                        src_restore = 1'b1;
                    end
                end
            end
            ST_STAB: begin
                if (tick) begin
                    if (at_edge) begin
                        state_d     = ST_RUN;
                        cnt_load    = 1'b1;
                        src_restore = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        clk_en    = 1'b1;
        wr_ok     = 1'b0;
        stab_mode = 1'b0;
        unique case (state_q)
            ST_RUN:  wr_ok = 1'b1;
            ST_WAIT: clk_en = 1'b1;
            ST_STOP: clk_en = 1'b0;
            ST_STAB: begin
                clk_en    = 1'b0;
                stab_mode = 1'b1;
            end
        endcase
    end

    assign state = state_q;
    assign irq   = irq_q;

endmodule

// File: rtl/wdt_wake_ctrl.sv
module wdt_wake_ctrl #(
    parameter int CNT_W    = 12,
    parameter int CTL_W    = 8,
    parameter int RATE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_d32,
    input  logic             tick_d128,
    input  logic             tick_d512,
    input  logic             wait_mode,
    input  logic             stop_exec,
    input  logic             wake_irq,
    input  logic             stop_use,
    input  logic             refresh,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic             wdt_irq,
    output logic             cpu_clk_en
);
    import wdt_wake_pkg::*;

    wdt_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             at_edge;
    logic             tick;
    logic             cnt_load;
    logic             cnt_dec;
    logic             src_capture;
    logic             src_restore;
    logic             wr_ok;
    logic             stab_mode;
    logic             run_fast;
    logic [1:0]       wake_src;

    wdt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_exec   (stop_exec),
        .wait_mode   (wait_mode),
        .wake_irq    (wake_irq),
        .stop_use    (stop_use),
        .refresh     (refresh),
        .tick        (tick),
        .at_edge     (at_edge),
        .state       (state),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec),
        .src_capture (src_capture),
        .src_restore (src_restore),
        .wr_ok       (wr_ok),
        .stab_mode   (stab_mode),
        .irq         (wdt_irq),
        .clk_en      (cpu_clk_en)
    );

    wdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .dec     (cnt_dec),
        .cnt     (cnt),
        .at_edge (at_edge)
    );

    wdt_ctl_reg #(.CTL_W(CTL_W), .RATE_BIT(RATE_BIT)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_we && wr_ok),
        .wdata    (ctl_wdata),
        .capture  (src_capture),
        .restore  (src_restore),
        .run_fast (run_fast),
        .wake_src (wake_src)
    );

    wdt_tick_sel u_sel (
        .tick_d32  (tick_d32),
        .tick_d128 (tick_d128),
        .tick_d512 (tick_d512),
        .stab_mode (stab_mode),
        .run_fast  (run_fast),
        .wake_src  (wake_src),
        .tick      (tick)
    );

endmodule

// File: rtl/wdt_wake_chk.sv
module wdt_wake_chk #(
    parameter int CNT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stop_exec,
    input  logic                     wake_irq,
    input  logic                     stop_use,
    input  logic                     wdt_irq,
    input  logic                     cpu_clk_en,
    input  wdt_wake_pkg::wdt_state_e state,
    input  logic [CNT_W-1:0]         cnt
);
    import wdt_wake_pkg::*;

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |=> !wdt_irq);

    // R7
    stab_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |=> !wdt_irq);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (cnt == $past(cnt)));

    // R6
    stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_exec) |=> (state == ST_STOP && (&cnt) && !cpu_clk_en));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wake_irq) |=> ($stable(cnt) && !cpu_clk_en));

    // R9
    wake_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && wake_irq && !stop_use) |=> (cpu_clk_en && (&cnt)));

endmodule

bind wdt_wake_ctrl wdt_wake_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_exec  (stop_exec),
    .wake_irq   (wake_irq),
    .stop_use   (stop_use),
    .wdt_irq    (wdt_irq),
    .cpu_clk_en (cpu_clk_en),
    .state      (state),
    .cnt        (cnt)
);

// File: tb/wdt_wake_ctrl_tb.sv
module wdt_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_d32 = 1'b0;
    logic       tick_d128 = 1'b0;
    logic       tick_d512 = 1'b0;
    logic       wait_mode = 1'b0;
    logic       stop_exec = 1'b0;
    logic       wake_irq = 1'b0;
    logic       stop_use = 1'b0;
    logic       refresh = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       wdt_irq;
    logic       cpu_clk_en;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    irq_seen = 0;
    string cur_req = "R1";

    // reference model state: 0 run, 1 wait, 2 stop, 3 stab
    int m_st = 0;
    int m_cnt = 4095;
    int m_fast = 0;
    int m_src = 0;
    int m_saved = 0;
    int m_irq = 0;

    always #2 clk = ~clk;

    wdt_wake_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_d32   (tick_d32),
        .tick_d128  (tick_d128),
        .tick_d512  (tick_d512),
        .wait_mode  (wait_mode),
        .stop_exec  (stop_exec),
        .wake_irq   (wake_irq),
        .stop_use   (stop_use),
        .refresh    (refresh),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .wdt_irq    (wdt_irq),
        .cpu_clk_en (cpu_clk_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // tick pattern: periods 2, 3 and 5 keep the sources distinguishable
    always @(negedge clk) begin
        cyc++;
        tick_d32  = (cyc % 2 == 0);
        tick_d128 = (cyc % 3 == 0);
        tick_d512 = (cyc % 5 == 0);
    end

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 4095; m_fast = 0; m_src = 0; m_saved = 0; m_irq = 0;
        end else begin
            int t_run;
            int t_stab;
            int nirq;
            nirq   = 0;
            t_run  = m_fast ? tick_d32 : tick_d512;
            t_stab = (m_src == 0) ? tick_d32 : (m_src == 1) ? tick_d512 : tick_d128;
            if (m_st == 0) begin
                if (stop_exec) begin
                    m_saved = m_fast; m_cnt = 4095; m_st = 2;
                end else if (wait_mode) begin
                    m_st = 1;
                end else if (refresh) begin
                    m_cnt = 4095;
                end else if (t_run != 0) begin
                    if (m_cnt == 2048) nirq = 1;
                    m_cnt = (m_cnt + 4095) % 4096;
                end
                if (ctl_we) begin
                    m_fast = ctl_wdata[0];
                    m_src  = ctl_wdata[7:6];
                end
            end else if (m_st == 1) begin
                if (!wait_mode) m_st = 0;
            end else if (m_st == 2) begin
                if (wake_irq) begin
                    m_cnt = 4095;
                    if (stop_use) m_st = 3;
                    else begin m_st = 0; m_fast = m_saved; end
                end
            end else begin
                if (t_stab != 0) begin
                    if (m_cnt == 2048) begin
                        m_st = 0; m_cnt = 4095; m_fast = m_saved;
                    end else m_cnt = m_cnt - 1;
                end
            end
            m_irq = nirq;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " clk_en"}, cpu_clk_en, (m_st >= 2) ? 0 : 1);
            chk({cur_req, " irq"}, wdt_irq, m_irq);
            if (wdt_irq) irq_seen++;
        end
    end

    task automatic ctl_write(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v; step(1);
        ctl_we = 1'b0; step(1);
    endtask

    task automatic pulse_refresh();
        refresh = 1'b1; step(1); refresh = 1'b0;
    endtask

    task automatic do_stop();
        stop_exec = 1'b1; step(1); stop_exec = 1'b0;
    endtask

    // wake and count falling edges until the clocks come back
    task automatic wake_measure(output int n);
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
        n = 1;
        while (!cpu_clk_en && n < 20000) begin
            step(1); n++;
        end
    endtask

    initial begin
        int base;
        int lat;
        step(3);
        // R1 reset state
        chk("R1 reset clk_en", cpu_clk_en, 1);
        chk("R1 reset irq", wdt_irq, 0);
        rst_n = 1'b1;

        // R1/R3: default divide-by-512, one request after 2048 ticks
        cur_req = "R3"; base = irq_seen;
        step(10300);
        chk("R1 default slow timeout", irq_seen - base, 1);

        // R2: fast rate
        cur_req = "R2";
        ctl_write(8'h01); pulse_refresh();
        base = irq_seen; step(4200);
        chk("R2 fast timeout", irq_seen - base, 1);

        // R4: regular refresh prevents requests
        cur_req = "R4"; base = irq_seen;
        for (int i = 0; i < 8; i++) begin
            pulse_refresh(); step(1000);
        end
        chk("R4 refreshed no irq", irq_seen - base, 0);

        // R5: wait freeze, resume without reload
        cur_req = "R5";
        pulse_refresh(); step(2000);
        base = irq_seen;
        wait_mode = 1'b1; step(5000); wait_mode = 1'b0;
        chk("R5 no irq in wait", irq_seen - base, 0);
        step(2300);
        chk("R5 resume from held value", irq_seen - base, 1);

        // R6/R7/R8: stop, stabilize on divide-by-128, resume fast
        cur_req = "R7";
        ctl_write(8'h81); stop_use = 1'b1;
        do_stop(); step(100);
        chk("R6 clk_en low in stop", cpu_clk_en, 0);
        base = irq_seen;
        wake_measure(lat);
        chk_range("R7 settle div128", lat, 6100, 6200);
        chk("R7 no irq on settle", irq_seen - base, 0);
        cur_req = "R8"; step(4200);
        chk("R8 pre-stop fast source", irq_seen - base, 1);

        // R7: field 01 selects divide-by-512, rate bit ignored
        cur_req = "R7";
        ctl_write(8'h41); do_stop(); step(20);
        wake_measure(lat);
        chk_range("R7 settle div512", lat, 10200, 10300);

        // R7: field 00 selects divide-by-32 while run source is slow
        ctl_write(8'h00); do_stop(); step(20);
        base = irq_seen;
        wake_measure(lat);
        chk_range("R7 settle div32", lat, 4050, 4150);
        cur_req = "R8"; step(4200);
        chk("R8 pre-stop slow source kept", irq_seen - base, 0);

        // R9: wake without stop use
        cur_req = "R9"; stop_use = 1'b0;
        ctl_write(8'h01); do_stop(); step(50);
        chk("R9 clk_en low before wake", cpu_clk_en, 0);
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
        chk("R9 clk_en next cycle", cpu_clk_en, 1);
        base = irq_seen; step(4200);
        chk("R9 fast source restored", irq_seen - base, 1);

        // R10: stop beats wait and refresh in the same cycle
        cur_req = "R10";
        stop_exec = 1'b1; wait_mode = 1'b1; refresh = 1'b1; step(1);
        stop_exec = 1'b0; wait_mode = 1'b0; refresh = 1'b0;
        chk("R10 stop wins", cpu_clk_en, 0);
        step(5);
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
        step(1000);
        wait_mode = 1'b1; refresh = 1'b1; step(1);
        refresh = 1'b0; step(200); wait_mode = 1'b0;
        base = irq_seen; step(3200);
        chk("R10 wait beats refresh", irq_seen - base, 1);

        // R1: reset during stop
        cur_req = "R1";
        do_stop(); step(30);
        rst_n = 1'b0; step(2);
        chk("R1 reset from stop clk_en", cpu_clk_en, 1);
        rst_n = 1'b1;
        base = irq_seen; step(4200);
        chk("R1 slow after reset", irq_seen - base, 0);
        step(6200);
        chk("R1 slow timeout after reset", irq_seen - base, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule